// File: doc/BRIEF.md
# Multi-Channel DMA Descriptor Push Front-End

This block is the register-mapped client side of a memory-to-memory DMA engine with several channels. Software picks a channel, loads a source address, a destination address and an attribute word, and then writes a length. The length write is the commit: the block finds a free slot in the selected channel's slice of a shared descriptor table and stores the four fields there. It then publishes the slot index as a handle, which later serves as the completion and error identifier. Each channel owns a contiguous range of slot indices given by a first-slot and a final-slot register. The slices can be reprogrammed.

The commit goes through a small state machine with three states: `ST_IDLE`, `ST_ALLOC` and `ST_COMMIT`. A length write accepted in `ST_IDLE` takes the transition *request* to `ST_ALLOC`. In `ST_ALLOC` the allocator picks a slot, or decides the channel is full, and latches that decision. The transition *decide* then moves unconditionally to `ST_COMMIT`. In `ST_COMMIT` the slot is written, marked outstanding and returned as the handle. If the channel was full, the push is dropped and the overflow flag is raised instead. The transition *finish* then returns unconditionally to `ST_IDLE`. The busy status bit is high in `ST_ALLOC` and `ST_COMMIT`, which is exactly two cycles.

A downstream consumer sees a one-cycle push pulse carrying the slot and channel. It reads the stored descriptor through a table read port and frees the slot with a retire strobe when it is finished. The bus transfer itself lives outside this block.

Top module: `dpf_push_frontend`

## Requirements
- R1: After reset the busy bit, the handle, the overflow flag and the interrupt pin are 0. Channel c's first-slot register reads c*4 and its final-slot register reads c*4+3 (16 slots, 4 channels).
- R2: The register offsets are: 0x00 channel select (2 bits, upper bits read 0), 0x01 source, 0x02 destination, 0x03 attribute, 0x04 length, 0x05 handle (read-only), 0x06 status (bit 0 busy), 0x07 overflow flag (bit 0), 0x08 control (bit 0 overflow interrupt enable), 0x10+2c first slot of channel c, 0x11+2c final slot of channel c. The attribute register keeps only bits 21:6 and 2:0; bits 5:3 and 31:22 read 0.
- R3: Writing the length register while idle starts a push. Busy reads 1 for the two cycles after the write edge. On the following edge the handle takes the chosen slot, push_valid pulses for one cycle with push_slot and push_chan, and the table entry holds the source, destination, masked attribute and length.
- R4: A length write larger than 0x1FFFF is stored as 0x1FFFF. Values up to 0x1FFFF are stored unchanged.
- R5: A push takes the first free slot at or after the channel's rotating pointer within its first..final range, wrapping from final to first. The pointer then moves to the slot after the one used, wrapping to the first slot after the final one.
- R6: A push into a channel whose whole range is outstanding is dropped. The handle stays unchanged, no push_valid pulse appears, and the overflow flag bit goes to 1.
- R7: ovf_irq equals the overflow flag ANDed with the enable bit. Writing 1 to bit 0 of offset 0x07 clears the flag.
- R8: While busy is 1, writes to offsets 0x00 to 0x04 are ignored. This includes a second length write, which starts no push.
- R9: A retire strobe frees its slot, so a later push into that full channel can use it again.
- R10: A channel whose final slot is below its first slot has no usable slots, and every push to it is dropped. A reprogrammed range takes effect for the next push.
- R11: When slots retire out of order, allocation skips the outstanding slots and takes the next free one in circular order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| retire_valid | input | 1 | Consumer frees a slot |
| retire_slot | input | 4 | Slot being freed |
| tbl_idx | input | 4 | Table read index |
| tbl_src | output | 32 | Stored source address |
| tbl_dst | output | 32 | Stored destination address |
| tbl_attr | output | 32 | Stored attribute word |
| tbl_len | output | 17 | Stored length |
| push_valid | output | 1 | One-cycle pulse per committed descriptor |
| push_slot | output | 4 | Slot of the committed descriptor |
| push_chan | output | 2 | Channel of the committed descriptor |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
A stale outstanding bit or rotating pointer shows up at the ports on the very next push to that channel. The wrong handle appears the third edge after the length write, and a slot that should be free can instead raise a false overflow. A state machine that skips or repeats a state changes the busy read within one cycle, and it moves the push pulse relative to the two-cycle window. The directed sequences fill a channel, retire slots out of order, reprogram a range to be empty and write during busy. Each of these misbehaviours therefore leaves a wrong handle, a wrong flag or a wrong pulse count within a few cycles.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
    localparam int REG_AW = 6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ALLOC  = 2'd1,
        ST_COMMIT = 2'd2
    } push_state_e;

    localparam logic [REG_AW-1:0] A_CHSEL  = 6'h00;
    localparam logic [REG_AW-1:0] A_SRC    = 6'h01;
    localparam logic [REG_AW-1:0] A_DST    = 6'h02;
    localparam logic [REG_AW-1:0] A_ATTR   = 6'h03;
    localparam logic [REG_AW-1:0] A_LEN    = 6'h04;
    localparam logic [REG_AW-1:0] A_HANDLE = 6'h05;
    localparam logic [REG_AW-1:0] A_STATUS = 6'h06;
    localparam logic [REG_AW-1:0] A_IRQ    = 6'h07;
    localparam logic [REG_AW-1:0] A_CTRL   = 6'h08;
    localparam int                A_RANGE0 = 16;

    // attribute fields kept: 21:6 and 2:0
    localparam logic [31:0] ATTR_MASK = 32'h003F_FFC7;
endpackage

// File: rtl/dpf_push_fsm.sv
module dpf_push_fsm
    import dpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic push_req_i,
    input  logic full_q_i,
    output logic busy_o,
    output logic decide_o,
    output logic commit_o,
    output logic drop_o
);
    push_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (push_req_i) state_d = ST_ALLOC;
            ST_ALLOC:  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o   = 1'b0;
        decide_o = 1'b0;
        commit_o = 1'b0;
        drop_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ALLOC: begin
                busy_o   = 1'b1;
                decide_o = 1'b1;
            end
            ST_COMMIT: begin
                busy_o   = 1'b1;
                commit_o = !full_q_i;
                drop_o   = full_q_i;
            end
            default:   ;
        endcase
    end

    p_req_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_req_i |=> (state_q == ST_ALLOC));
    p_alloc_then_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALLOC) |=> (state_q == ST_COMMIT));
    p_commit_then_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/dpf_slot_alloc.sv
module dpf_slot_alloc #(
    parameter int NUM_CH    = 4,
    parameter int NUM_SLOTS = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [$clog2(NUM_CH)-1:0]              chan_i,
    input  logic [NUM_CH-1:0][$clog2(NUM_SLOTS)-1:0] base_i,
    input  logic [NUM_CH-1:0][$clog2(NUM_SLOTS)-1:0] last_i,
    input  logic                                   decide_i,
    input  logic                                   commit_i,
    input  logic                                   retire_valid_i,
    input  logic [$clog2(NUM_SLOTS)-1:0]           retire_slot_i,
    output logic                                   full_q_o,
    output logic [$clog2(NUM_SLOTS)-1:0]           slot_q_o
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int SPAN   = NUM_SLOTS / NUM_CH;

    logic [NUM_SLOTS-1:0]             out_q;
    logic [NUM_CH-1:0][SLOT_W-1:0]    ptr_q;
    logic [SLOT_W:0]                  b, l, span, start, cand;
    logic                             found;
    logic [SLOT_W-1:0]                pick;

    // circular search for the first free slot from the pointer
    always_comb begin
        b     = {1'b0, base_i[chan_i]};
        l     = {1'b0, last_i[chan_i]};
        span  = (l >= b) ? (l - b + 1'b1) : '0;
        start = ({1'b0, ptr_q[chan_i]} >= b && {1'b0, ptr_q[chan_i]} <= l)
                ? {1'b0, ptr_q[chan_i]} : b;
        found = 1'b0;
        pick  = base_i[chan_i];
        cand  = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            cand = start + (SLOT_W+1)'(k);
            if (cand > l) cand = cand - span;
            if (!found && ((SLOT_W+1)'(k) < span) && !out_q[cand[SLOT_W-1:0]]) begin
                found = 1'b1;
                pick  = cand[SLOT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q    <= '0;
            full_q_o <= 1'b0;
            slot_q_o <= '0;
            for (int c = 0; c < NUM_CH; c++) ptr_q[c] <= SLOT_W'(c * SPAN);
        end else begin
            if (decide_i) begin
                full_q_o <= !found;
                slot_q_o <= pick;
            end
            if (retire_valid_i) out_q[retire_slot_i] <= 1'b0;
            if (commit_i) begin
                out_q[slot_q_o] <= 1'b1;
                ptr_q[chan_i]   <= (slot_q_o == last_i[chan_i]) ? base_i[chan_i]
                                                                : slot_q_o + 1'b1;
            end
        end
    end

    p_commit_free_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> !out_q[slot_q_o]);
    p_empty_range_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_i && span == '0) |=> full_q_o);
endmodule

// File: rtl/dpf_regs.sv
module dpf_regs
    import dpf_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_SLOTS = 16,
    parameter int DW        = 32,
    parameter int LEN_W     = 17,
    parameter int LEN_MAX   = 'h1FFFF
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [REG_AW-1:0]                      wr_addr,
    input  logic [DW-1:0]                          wr_data,
    input  logic [REG_AW-1:0]                      rd_addr,
    output logic [DW-1:0]                          rd_data,
    input  logic                                   busy_i,
    input  logic                                   commit_i,
    input  logic                                   drop_i,
    input  logic [$clog2(NUM_SLOTS)-1:0]           slot_i,
    output logic [$clog2(NUM_CH)-1:0]              chsel_o,
    output logic [DW-1:0]                          src_o,
    output logic [DW-1:0]                          dst_o,
    output logic [DW-1:0]                          attr_o,
    output logic [LEN_W-1:0]                       len_o,
    output logic [NUM_CH-1:0][$clog2(NUM_SLOTS)-1:0] base_o,
    output logic [NUM_CH-1:0][$clog2(NUM_SLOTS)-1:0] last_o,
    output logic                                   push_req_o,
    output logic                                   ovf_irq_o
);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int SPAN   = NUM_SLOTS / NUM_CH;

    logic              client_ok;
    logic [SLOT_W-1:0] handle_q;
    logic              ovf_en_q, ovf_flag_q;

    assign client_ok  = wr_en && !busy_i;
    assign push_req_o = client_ok && (wr_addr == A_LEN);
    assign ovf_irq_o  = ovf_flag_q && ovf_en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chsel_o    <= '0;
            src_o      <= '0;
            dst_o      <= '0;
            attr_o     <= '0;
            len_o      <= '0;
            handle_q   <= '0;
            ovf_en_q   <= 1'b0;
            ovf_flag_q <= 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
                base_o[c] <= SLOT_W'(c * SPAN);
                last_o[c] <= SLOT_W'(c * SPAN + SPAN - 1);
            end
        end else begin
            if (client_ok) begin
                case (wr_addr)
                    A_CHSEL: chsel_o <= wr_data[CH_W-1:0];
                    A_SRC:   src_o   <= wr_data;
                    A_DST:   dst_o   <= wr_data;
                    A_ATTR:  attr_o  <= wr_data & ATTR_MASK;
                    A_LEN:   len_o   <= (wr_data > DW'(LEN_MAX)) ? LEN_W'(LEN_MAX)
                                                                 : wr_data[LEN_W-1:0];
                    default: ;
                endcase
            end
            if (wr_en && wr_addr == A_CTRL) ovf_en_q <= wr_data[0];
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_en && wr_addr == REG_AW'(A_RANGE0 + 2 * c))     base_o[c] <= wr_data[SLOT_W-1:0];
                if (wr_en && wr_addr == REG_AW'(A_RANGE0 + 2 * c + 1)) last_o[c] <= wr_data[SLOT_W-1:0];
            end
            if (drop_i)                                           ovf_flag_q <= 1'b1;
            else if (wr_en && wr_addr == A_IRQ && wr_data[0])     ovf_flag_q <= 1'b0;
            if (commit_i) handle_q <= slot_i;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CHSEL:  rd_data = DW'(chsel_o);
            A_SRC:    rd_data = src_o;
            A_DST:    rd_data = dst_o;
            A_ATTR:   rd_data = attr_o;
            A_LEN:    rd_data = DW'(len_o);
            A_HANDLE: rd_data = DW'(handle_q);
            A_STATUS: rd_data = DW'(busy_i);
            A_IRQ:    rd_data = DW'(ovf_flag_q);
            A_CTRL:   rd_data = DW'(ovf_en_q);
            default: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (rd_addr == REG_AW'(A_RANGE0 + 2 * c))     rd_data = DW'(base_o[c]);
                    if (rd_addr == REG_AW'(A_RANGE0 + 2 * c + 1)) rd_data = DW'(last_o[c]);
                end
            end
        endcase
    end

    p_drop_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drop_i |=> ovf_flag_q);
    p_drop_keeps_handle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drop_i |=> $stable(handle_q));
    p_commit_handle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (handle_q == $past(slot_i)));
    p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && wr_en && wr_addr == A_SRC) |=> $stable(src_o));
endmodule

// File: rtl/dpf_push_frontend.sv
module dpf_push_frontend
    import dpf_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_SLOTS = 16,
    parameter int DW        = 32,
    parameter int LEN_W     = 17,
    parameter int LEN_MAX   = 'h1FFFF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [5:0]                   wr_addr,
    input  logic [DW-1:0]                wr_data,
    input  logic [5:0]                   rd_addr,
    output logic [DW-1:0]                rd_data,
    input  logic                         retire_valid,
    input  logic [$clog2(NUM_SLOTS)-1:0] retire_slot,
    input  logic [$clog2(NUM_SLOTS)-1:0] tbl_idx,
    output logic [DW-1:0]                tbl_src,
    output logic [DW-1:0]                tbl_dst,
    output logic [DW-1:0]                tbl_attr,
    output logic [LEN_W-1:0]             tbl_len,
    output logic                         push_valid,
    output logic [$clog2(NUM_SLOTS)-1:0] push_slot,
    output logic [$clog2(NUM_CH)-1:0]    push_chan,
    output logic                         ovf_irq
);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int SLOT_W = $clog2(NUM_SLOTS);

    logic                          busy, decide, commit, drop, push_req, full_q;
    logic [SLOT_W-1:0]             slot_q;
    logic [CH_W-1:0]               chsel;
    logic [DW-1:0]                 src, dst, attr;
    logic [LEN_W-1:0]              len;
    logic [NUM_CH-1:0][SLOT_W-1:0] base, last;

    logic [DW-1:0]    t_src  [NUM_SLOTS];
    logic [DW-1:0]    t_dst  [NUM_SLOTS];
    logic [DW-1:0]    t_attr [NUM_SLOTS];
    logic [LEN_W-1:0] t_len  [NUM_SLOTS];

    dpf_regs #(
        .NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .DW(DW), .LEN_W(LEN_W), .LEN_MAX(LEN_MAX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy_i(busy), .commit_i(commit),
        .drop_i(drop), .slot_i(slot_q), .chsel_o(chsel), .src_o(src), .dst_o(dst),
        .attr_o(attr), .len_o(len), .base_o(base), .last_o(last),
        .push_req_o(push_req), .ovf_irq_o(ovf_irq)
    );

    dpf_slot_alloc #(.NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS)) u_alloc (
        .clk(clk), .rst_n(rst_n), .chan_i(chsel), .base_i(base), .last_i(last),
        .decide_i(decide), .commit_i(commit), .retire_valid_i(retire_valid),
        .retire_slot_i(retire_slot), .full_q_o(full_q), .slot_q_o(slot_q)
    );

    dpf_push_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .push_req_i(push_req), .full_q_i(full_q),
        .busy_o(busy), .decide_o(decide), .commit_o(commit), .drop_o(drop)
    );

    always_ff @(posedge clk) begin
        if (commit) begin
            t_src[slot_q]  <= src;
            t_dst[slot_q]  <= dst;
            t_attr[slot_q] <= attr;
            t_len[slot_q]  <= len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_valid <= 1'b0;
            push_slot  <= '0;
            push_chan  <= '0;
        end else begin
            push_valid <= commit;
            if (commit) begin
                push_slot <= slot_q;
                push_chan <= chsel;
            end
        end
    end

    assign tbl_src  = t_src[tbl_idx];
    assign tbl_dst  = t_dst[tbl_idx];
    assign tbl_attr = t_attr[tbl_idx];
    assign tbl_len  = t_len[tbl_idx];

    p_push_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> !push_valid);
endmodule

// File: tb/dpf_push_frontend_bench.sv
module dpf_push_frontend_bench;
    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        retire_valid = 1'b0;
    logic [3:0]  retire_slot = '0;
    logic [3:0]  tbl_idx = '0;
    logic [31:0] tbl_src, tbl_dst, tbl_attr;
    logic [16:0] tbl_len;
    logic        push_valid;
    logic [3:0]  push_slot;
    logic [1:0]  push_chan;
    logic        ovf_irq;

    int checks = 0;
    int fails = 0;
    int pulse_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) if (push_valid) pulse_cnt <= pulse_cnt + 1;

    dpf_push_frontend u_dpf_push_frontend (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .retire_valid(retire_valid),
        .retire_slot(retire_slot), .tbl_idx(tbl_idx), .tbl_src(tbl_src),
        .tbl_dst(tbl_dst), .tbl_attr(tbl_attr), .tbl_len(tbl_len),
        .push_valid(push_valid), .push_slot(push_slot), .push_chan(push_chan),
        .ovf_irq(ovf_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic retire(input logic [3:0] s);
        @(negedge clk);
        retire_valid = 1'b1; retire_slot = s;
        @(negedge clk);
        retire_valid = 1'b0;
    endtask

    task automatic push(input int ch, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] a, input logic [31:0] l,
                        input bit ok, input logic [3:0] h, input string tag);
        logic [31:0] v;
        logic [31:0] exp_len;
        wr(6'h00, 32'(ch)); wr(6'h01, s); wr(6'h02, d); wr(6'h03, a); wr(6'h04, l);
        rd(6'h06, v); chk({tag, " R3 busy cycle1"}, v, 32'd1);
        @(negedge clk);
        rd(6'h06, v); chk({tag, " R3 busy cycle2"}, v, 32'd1);
        @(negedge clk);
        rd(6'h06, v); chk({tag, " R3 busy cleared"}, v, 32'd0);
        chk({tag, " push_valid"}, {31'd0, push_valid}, {31'd0, ok});
        rd(6'h05, v); chk({tag, " handle"}, v, {28'd0, h});
        if (ok) begin
            chk({tag, " R3 push_slot"}, {28'd0, push_slot}, {28'd0, h});
            chk({tag, " R3 push_chan"}, {30'd0, push_chan}, 32'(ch));
            tbl_idx = h;
            #1;
            exp_len = (l > 32'h1FFFF) ? 32'h1FFFF : l;
            chk({tag, " R3 tbl src"}, tbl_src, s);
            chk({tag, " R3 tbl dst"}, tbl_dst, d);
            chk({tag, " R2 tbl attr"}, tbl_attr, a & 32'h003F_FFC7);
            chk({tag, " R4 tbl len"}, {15'd0, tbl_len}, exp_len);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(6'h06, v); chk("R1 busy", v, 0);
        rd(6'h05, v); chk("R1 handle", v, 0);
        rd(6'h07, v); chk("R1 ovf flag", v, 0);
        chk("R1 irq", {31'd0, ovf_irq}, 0);
        rd(6'h12, v); chk("R1 ch1 first", v, 4);
        rd(6'h13, v); chk("R1 ch1 final", v, 7);
        rd(6'h17, v); chk("R1 ch3 final", v, 15);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(6'h00, 32'd5);           rd(6'h00, v); chk("R2 chsel width", v, 1);
        wr(6'h03, 32'hFFFF_FFFF);   rd(6'h03, v); chk("R2 attr mask", v, 32'h003F_FFC7);
        wr(6'h01, 32'hCAFE_0001);   rd(6'h01, v); chk("R2 src readback", v, 32'hCAFE_0001);
    endtask

    task automatic t_basic();
        push(0, 32'h1000, 32'h2000, 32'h0000_0003, 32'h100, 1'b1, 4'd0, "R3 ch0 first");
        push(0, 32'h1100, 32'h2100, 32'h00FF_FFFF, 32'h200, 1'b1, 4'd1, "R5 ch0 second");
    endtask

    task automatic t_len_sat();
        push(0, 32'h3000, 32'h4000, 32'h1, 32'h1234_5678, 1'b1, 4'd2, "R4 over max");
        push(0, 32'h3100, 32'h4100, 32'h1, 32'h0001_FFFF, 1'b1, 4'd3, "R4 at max");
    endtask

    task automatic t_full_irq();
        logic [31:0] v;
        for (int i = 0; i < 4; i++)
            push(1, 32'h5000 + 32'(i), 32'h6000, 32'h2, 32'h40, 1'b1, 4'(4 + i), "R5 ch1 fill");
        push(1, 32'h5555, 32'h6666, 32'h2, 32'h40, 1'b0, 4'd7, "R6 ch1 full drop");
        rd(6'h07, v); chk("R6 ovf flag set", v, 1);
        chk("R7 irq masked", {31'd0, ovf_irq}, 0);
        tbl_idx = 4'd4; #1; chk("R6 table untouched", tbl_src, 32'h5000);
        wr(6'h08, 32'd1);
        chk("R7 irq enabled", {31'd0, ovf_irq}, 1);
        wr(6'h07, 32'd1);
        rd(6'h07, v); chk("R7 flag cleared", v, 0);
        chk("R7 irq cleared", {31'd0, ovf_irq}, 0);
    endtask

    task automatic t_retire();
        retire(4'd5);
        push(1, 32'h7000, 32'h7100, 32'h0, 32'h10, 1'b1, 4'd5, "R11 skip outstanding");
        retire(4'd7);
        push(1, 32'h7200, 32'h7300, 32'h0, 32'h10, 1'b1, 4'd7, "R9 reuse retired");
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int p0;
        wr(6'h00, 32'd2); wr(6'h01, 32'h1111); wr(6'h02, 32'h2222); wr(6'h03, 32'h1);
        p0 = pulse_cnt;
        wr(6'h04, 32'h40);
        wr_en = 1'b1; wr_addr = 6'h01; wr_data = 32'h0BAD;
        @(negedge clk);
        wr_addr = 6'h04; wr_data = 32'h80;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 single push", 32'(pulse_cnt - p0), 1);
        rd(6'h01, v); chk("R8 src kept", v, 32'h1111);
        rd(6'h04, v); chk("R8 len kept", v, 32'h40);
        rd(6'h05, v); chk("R8 handle", v, 8);
    endtask

    task automatic t_ranges();
        logic [31:0] v;
        wr(6'h16, 32'd10); wr(6'h17, 32'd9);
        push(3, 32'h8000, 32'h8100, 32'h0, 32'h8, 1'b0, 4'd8, "R10 empty range drop");
        rd(6'h07, v); chk("R10 ovf flag", v, 1);
        chk("R7 irq asserted", {31'd0, ovf_irq}, 1);
        wr(6'h07, 32'd1);
        wr(6'h16, 32'd14); wr(6'h17, 32'd15);
        rd(6'h16, v); chk("R10 first readback", v, 14);
        push(3, 32'h8200, 32'h8300, 32'h0, 32'h8, 1'b1, 4'd14, "R10 new range a");
        push(3, 32'h8400, 32'h8500, 32'h0, 32'h8, 1'b1, 4'd15, "R10 new range b");
        push(3, 32'h8600, 32'h8700, 32'h0, 32'h8, 1'b0, 4'd15, "R10 new range full");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_basic();
        t_len_sat();
        t_full_irq();
        t_retire();
        t_busy_ignore();
        t_ranges();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule